// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a 16-bit converter that is loaded over a three-wire serial link. The three link wires are an active-low select, a serial clock and a data line. They arrive without any timing relation to the block's own system clock. Each wire passes through a synchroniser, and its edges are then found in the system clock domain. That domain must run at least four times faster than the serial clock.

While select is low, each rising serial-clock edge shifts one data bit into a word, most significant bit first, and a counter tracks how many bits have arrived. When select returns high, the frame is judged. If it held exactly 16 bits, the word moves into the parallel converter latch and a one-cycle update strobe is raised. If it held any other number of bits, the latch keeps its old value and a one-cycle frame-error pulse is raised instead. Reset clears the latch to code 0x0000, which is the zero-output code.

Top module: `sdac_frontend`

## Requirements
- R1: During and right after reset, `dac_code` is 0x0000 and both `dac_update` and `frame_err` are low.
- R2: A frame of exactly 16 rising serial-clock edges, with select low, loads the latch. The first bit sent lands in bit 15 of `dac_code` and the last bit sent lands in bit 0.
- R3: `dac_update` is high for exactly one cycle for each accepted frame. `dac_code` never changes in a cycle without that strobe.
- R4: A frame with fewer than 16 bits, including a frame with none, leaves `dac_code` unchanged. It raises `frame_err` for one cycle and gives no update strobe.
- R5: A frame with more than 16 bits is rejected in the same way as in R4. Bits after the 16th do not shift the word.
- R6: Serial-clock and data activity while select is high has no effect on `dac_code`, `dac_update` or `frame_err`.
- R7: Each falling edge of select starts a fresh bit count, so a rejected frame does not prevent the next 16-bit frame from loading.
- R8: The new `dac_code` and `dac_update` appear on the third system-clock edge after `cs_n_in` rises: two edges of synchronisation and one edge of latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n_in | input | 1 | Asynchronous active-low frame select |
| sclk_in | input | 1 | Asynchronous serial clock; data is taken on its rising edge |
| sdata_in | input | 1 | Asynchronous serial data, most significant bit first |
| dac_code | output | 16 | Parallel converter latch value |
| dac_update | output | 1 | One-cycle strobe when the latch takes a new word |
| frame_err | output | 1 | One-cycle pulse when a frame with a bit count other than 16 is rejected |

## Verification
A wrong bit count or a shifted word shows at the ports three system cycles after select rises. It appears as a strobe where an error pulse was due, as an error pulse where a strobe was due, or as a latch value whose bits are rotated or out of order. A latch that changes without a strobe, or a strobe that lasts more than one cycle, is visible within one cycle. An extra shift while select is high, or after the 16th bit, shows up only when a later frame is accepted or rejected.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE   = 2'd0,
    VERDICT_ACCEPT = 2'd1,
    VERDICT_REJECT = 2'd2
  } verdict_e;

  // Saturating bit counter step: stops at cap.
  function automatic int unsigned sat_inc(input int unsigned c, input int unsigned cap);
    return (c >= cap) ? cap : c + 1;
  endfunction

  // Frame judgement on a select rising edge.
  function automatic verdict_e judge(input logic edge_seen, input int unsigned cnt,
                                     input int unsigned word_w);
    if (!edge_seen) return VERDICT_NONE;
    return (cnt == word_w) ? VERDICT_ACCEPT : VERDICT_REJECT;
  endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else        stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam int unsigned CAP = WORD_W + 1;

  logic take_bit;
  logic frame_over;

  assign take_bit   = !cs_lvl && sclk_rise && !cs_fall;
  assign frame_over = (int'(bit_cnt) >= WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (take_bit) begin
      if (!frame_over) word <= {word[WORD_W-2:0], din};
      bit_cnt <= CNT_W'(sat_inc(int'(bit_cnt), CAP));
    end
  end

  // R5: the counter saturates one past a full word
  assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) <= WORD_W + 1);

  // R5: no shifting once the word is full
  assert_no_shift_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_over |=> $stable(word));

  // R6: nothing shifts while select is high
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> $stable(word));

  // R7: a select fall restarts the count
  assert_fresh_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (bit_cnt == '0));
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] code,
  output logic              update,
  output logic              err
);
  verdict_e verdict;

  assign verdict = judge(cs_rise, int'(bit_cnt), WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= '0;
      update <= 1'b0;
      err    <= 1'b0;
    end else begin
      update <= (verdict == VERDICT_ACCEPT);
      err    <= (verdict == VERDICT_REJECT);
      if (verdict == VERDICT_ACCEPT) code <= word;
    end
  end

  // R2: a full frame at select rise is accepted
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && int'(bit_cnt) == WORD_W) |=> (update && code == $past(word)));

  // R3: the strobe lasts a single cycle
  assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !update);

  // R3: the latch moves only with the strobe
  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> update);

  // R4: any other count is rejected
  assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && int'(bit_cnt) != WORD_W) |=> (err && !update));

  // R4: an error and an update never coincide
  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && update));
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_in,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic [WORD_W-1:0] dac_code,
  output logic              dac_update,
  output logic              frame_err
);
  logic [2:0]        raw_in;
  logic [2:0]        sync_q;
  logic              cs_q, sclk_q, data_q;
  logic              cs_prev, sclk_prev;
  logic              cs_rise, cs_fall, sclk_rise;
  logic [WORD_W-1:0] shift_word;
  logic [CNT_W-1:0]  bit_cnt;

  assign raw_in = {cs_n_in, sclk_in, sdata_in};

  // Select idles high; clock and data idle low.
  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
  );

  assign {cs_q, sclk_q, data_q} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_q;
      sclk_prev <= sclk_q;
    end
  end

  assign cs_rise   = cs_q && !cs_prev;
  assign cs_fall   = !cs_q && cs_prev;
  assign sclk_rise = sclk_q && !sclk_prev;

  sdac_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_q), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .din(data_q), .word(shift_word), .bit_cnt(bit_cnt)
  );

  sdac_latch #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
    .word(shift_word), .code(dac_code), .update(dac_update), .err(frame_err)
  );

  // R6: outputs stay quiet unless select has just risen
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> (!dac_update && !frame_err));
endmodule

// File: tb/tb_sdac_frontend.sv
module tb_sdac_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n_in = 1'b1, sclk_in = 1'b0, sdata_in = 1'b0;
  logic [15:0] dac_code;
  logic        dac_update, frame_err;

  int errors = 0, checks = 0;
  int upd_seen = 0, err_seen = 0;
  logic [15:0] model = 16'h0000;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  sdac_frontend dut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
    .sdata_in(sdata_in), .dac_code(dac_code), .dac_update(dac_update),
    .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (dac_update) upd_seen++;
    if (frame_err)  err_seen++;
  end

  function automatic bit frame_ok(input int nbits);
    return nbits == 16;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input int nbits, input logic [15:0] w);
    for (int i = 0; i < nbits; i++) begin
      sdata_in = (i < 16) ? w[15-i] : 1'($urandom % 2);
      wait_clk(4);
      sclk_in = 1'b1;
      wait_clk(4);
      sclk_in = 1'b0;
    end
  endtask

  task automatic frame(input string tag, input int nbits, input logic [15:0] w);
    int u0, e0;
    u0 = upd_seen; e0 = err_seen;
    cs_n_in = 1'b0;
    wait_clk(4);
    shift_bits(nbits, w);
    wait_clk(4);
    cs_n_in = 1'b1;
    wait_clk(8);
    if (frame_ok(nbits)) model = w;
    chk({tag, " code"}, 32'(dac_code), 32'(model));
    chk({tag, " strobes"}, 32'(upd_seen - u0), frame_ok(nbits) ? 32'd1 : 32'd0);
    chk({tag, " errors"}, 32'(err_seen - e0), frame_ok(nbits) ? 32'd0 : 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5DAC));
    wait_clk(3);
    chk("R1 reset code", 32'(dac_code), 32'h0);
    chk("R1 reset flags", {30'd0, dac_update, frame_err}, 32'h0);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1 after reset", {14'd0, dac_update, frame_err, dac_code}, 32'h0);

    frame("R2 all ones", 16, 16'hFFFF);
    frame("R2 msb only", 16, 16'h8000);
    frame("R2 lsb only", 16, 16'h0001);
    frame("R2 order", 16, 16'hA5C3);

    // R8 latency: third edge after select rises
    cs_n_in = 1'b0; wait_clk(4);
    shift_bits(16, 16'h1234); wait_clk(4);
    cs_n_in = 1'b1;
    wait_clk(2);
    chk("R8 not yet code", 32'(dac_code), 32'hA5C3);
    chk("R8 not yet strobe", 32'(dac_update), 32'h0);
    wait_clk(1);
    chk("R8 code on third edge", 32'(dac_code), 32'h1234);
    chk("R3 strobe high", 32'(dac_update), 32'h1);
    wait_clk(1);
    chk("R3 strobe one cycle", 32'(dac_update), 32'h0);
    model = 16'h1234;
    wait_clk(4);

    frame("R4 fifteen bits", 15, 16'hFFFF);
    frame("R4 empty frame", 0, 16'h0F0F);
    frame("R4 one bit", 1, 16'h8000);
    frame("R5 seventeen bits", 17, 16'h4321);
    frame("R5 thirty two bits", 32, 16'hBEEF);
    frame("R7 good after bad", 16, 16'h0000);
    frame("R7 short", 9, 16'h7777);
    frame("R7 recover", 16, 16'hC001);

    // R6: activity with select high
    begin
      int u0, e0;
      u0 = upd_seen; e0 = err_seen;
      shift_bits(20, 16'hFFFF);
      wait_clk(8);
      chk("R6 code kept", 32'(dac_code), 32'(model));
      chk("R6 no pulses", 32'((upd_seen - u0) + (err_seen - e0)), 32'h0);
    end

    for (int k = 0; k < 40; k++) begin
      int n;
      n = ($urandom % 3 == 0) ? int'($urandom % 21) : 16;
      frame(frame_ok(n) ? "R2 random accept" : "R4 R5 random reject", n, 16'($urandom));
    end

    rst_n = 1'b0;
    wait_clk(2);
    chk("R1 reset clears latch", 32'(dac_code), 32'h0);
    rst_n = 1'b1;
    wait_clk(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule